// File: doc/BRIEF.md
# Two-Digit Decimal Multiplier

This block multiplies two unsigned two-digit decimal numbers, each given as a byte of packed BCD with the tens digit in the upper nibble. The result is a four-digit packed BCD product. The block is purely combinational: a result appears at the output as soon as the operands settle, and there is no clock or storage inside.

The four digit pairs are multiplied in binary at the same time. Each digit product fits in seven bits, because the largest is 81. Each product is then turned into its own tens and units digits, still in parallel. The four two-digit terms are shifted by the sum of their digit weights and added with decimal adders that correct each digit sum. If any input nibble is not a decimal digit, a flag goes high and the product is held at zero.

Top module: `bcd_mul2`

## Requirements
- R1: When all four input nibbles are in 0..9, `prod` equals the decimal product of `op_x` and `op_y`. The output is packed as four BCD digits, thousands in bits 15:12 and units in bits 3:0.
- R2: `bad_digit` is 1 exactly when at least one of the four input nibbles holds a code from 10 to 15 (1010 to 1111).
- R3: While `bad_digit` is 1, `prod` is 16'h0000.
- R4: Every nibble of `prod` is in 0..9 for any input.
- R5: Each digit product lies in 0..81 and is split into a tens digit and a units digit, each in 0..9. A single-digit product such as 9 x 9 appears as 16'h0081.
- R6: Decimal carries ripple across all output digits. For example, 99 x 99 gives 16'h9801 and 25 x 4 gives 16'h0100.
- R7: The product of tens digit i and units digit j is weighted by 10^(i+j). For example, 10 x 10 gives 16'h0100 and 90 x 90 gives 16'h8100.
- R8: A zero operand gives a zero product and a clear flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | 8 | Multiplicand, two packed BCD digits, tens in bits 7:4 |
| op_y | input | 8 | Multiplier, two packed BCD digits, tens in bits 7:4 |
| prod | output | 16 | Product, four packed BCD digits, thousands in bits 15:12 |
| bad_digit | output | 1 | High when any input nibble is 10 or above |

## Verification
The two functions that can act at the same time are the correction of digit sums above nine and the alignment of the cross terms. Both come into play when the middle columns receive three overlapping digits, for example in 99 x 99, 95 x 95 and 19 x 91. The bench covers this by sweeping every valid operand pair and comparing each result with a product computed in the bench and then converted to BCD. It also mixes in random bytes with invalid nibbles and checks that the flag is set and the output is held at zero.

// File: rtl/bcd_mul2.sv
module bcd_mul2 (
  input  logic [7:0]  op_x,
  input  logic [7:0]  op_y,
  output logic [15:0] prod,
  output logic        bad_digit
);

  logic [6:0]  pp [4];
  logic [3:0]  tn [4];
  logic [3:0]  un [4];
  logic [15:0] t00, t01, t10, t11, s_a, s_b, s_c;

  function automatic logic [15:0] dec_add(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r;
    logic [4:0]  s;
    logic        cy;
    r  = '0;
    cy = 1'b0;
    for (int i = 0; i < 4; i++) begin
      s = {1'b0, a[i*4 +: 4]} + {1'b0, b[i*4 +: 4]} + {4'b0, cy};
      if (s > 5'd9) begin
        s  = s + 5'd6;
        cy = 1'b1;
      end else begin
        cy = 1'b0;
      end
      r[i*4 +: 4] = s[3:0];
    end
    return r;
  endfunction

  assign bad_digit = (op_x[7:4] > 4'd9) || (op_x[3:0] > 4'd9) ||
                     (op_y[7:4] > 4'd9) || (op_y[3:0] > 4'd9);

  // index k: bit1 selects digit of x, bit0 selects digit of y
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      logic [3:0] xd, yd, t;
      xd = k[1] ? op_x[7:4] : op_x[3:0];
      yd = k[0] ? op_y[7:4] : op_y[3:0];
      pp[k] = {3'b0, xd} * {3'b0, yd};
      t = 4'd0;
      for (int m = 1; m < 10; m++)
        if (pp[k] >= 7'(10 * m)) t = 4'(m);
      tn[k] = t;
      un[k] = 4'(pp[k] - 7'(10 * t));
    end
  end

  assign t00 = {8'h00, tn[0], un[0]};
  assign t01 = {4'h0, tn[1], un[1], 4'h0};
  assign t10 = {4'h0, tn[2], un[2], 4'h0};
  assign t11 = {tn[3], un[3], 8'h00};

  assign s_a = dec_add(t00, t01);
  assign s_b = dec_add(t10, t11);
  assign s_c = dec_add(s_a, s_b);

  assign prod = bad_digit ? 16'h0000 : s_c;

  always_comb begin
    AST_ZERO_WHEN_BAD: assert (!bad_digit || prod == 16'h0000); // R3
    AST_OUT_DIGITS: assert (prod[15:12] <= 4'd9 && prod[11:8] <= 4'd9 &&
                            prod[7:4] <= 4'd9 && prod[3:0] <= 4'd9); // R4
    for (int k = 0; k < 4; k++) begin
      AST_PP_RANGE: assert (bad_digit || pp[k] <= 7'd81); // R5
      AST_SPLIT_OK: assert (bad_digit || (tn[k] <= 4'd9 && un[k] <= 4'd9 &&
                            7'(tn[k] * 10) + 7'(un[k]) == pp[k])); // R5
    end
    AST_ZERO_OPERAND: assert (!(op_x == 8'h00 && op_y[3:0] <= 4'd9 && op_y[7:4] <= 4'd9)
                              || (prod == 16'h0000 && !bad_digit)); // R8
  end

endmodule

// File: tb/tb_bcd_mul2.sv
module tb_bcd_mul2;
  logic        clk = 1'b0;
  logic [7:0]  op_x = 8'h00, op_y = 8'h00;
  logic [15:0] prod;
  logic        bad_digit;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_mul2 dut (.op_x(op_x), .op_y(op_y), .prod(prod), .bad_digit(bad_digit));

  function automatic logic [15:0] to_bcd(input int n);
    return {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  function automatic bit is_bad(input logic [7:0] a, input logic [7:0] b);
    return a[7:4] > 9 || a[3:0] > 9 || b[7:4] > 9 || b[3:0] > 9;
  endfunction

  function automatic int val(input logic [7:0] a);
    return a[7:4] * 10 + a[3:0];
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input string tag);
    logic [15:0] ep;
    logic        eb;
    @(negedge clk);
    op_x = a;
    op_y = b;
    #2;
    eb = is_bad(a, b);
    ep = eb ? 16'h0000 : to_bcd(val(a) * val(b));
    checks++;
    if (prod !== ep || bad_digit !== eb) begin
      fails++;
      $display("FAIL %s x=%h y=%h prod=%h bad=%b expected prod=%h bad=%b",
               tag, a, b, prod, bad_digit, ep, eb);
    end
  endtask

  initial begin
    #200_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    apply(8'h00, 8'h00, "R8 reset-state zero");
    apply(8'h00, 8'h57, "R8 zero operand");
    apply(8'h09, 8'h09, "R5 single digit 81");
    apply(8'h99, 8'h99, "R6 full carry 9801");
    apply(8'h25, 8'h04, "R6 carry to hundreds");
    apply(8'h95, 8'h95, "R6 overlapping columns");
    apply(8'h10, 8'h10, "R7 weight 100");
    apply(8'h90, 8'h90, "R7 weight 8100");
    apply(8'h19, 8'h91, "R7 cross terms");
    apply(8'hA0, 8'h11, "R2 R3 bad x tens");
    apply(8'h11, 8'h0F, "R2 R3 bad y units");
    apply(8'hFF, 8'hFF, "R2 R3 all bad");
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b++)
        apply(to_bcd(a)[7:0], to_bcd(b)[7:0], "R1 R4 sweep");
    for (int n = 0; n < 2000; n++)
      apply(8'($urandom), 8'($urandom), "R2 R3 R4 random");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule